// File: doc/BRIEF.md
# Interrupt-Driven Event Sequencer

This block is a tiny programmable controller for a low-power sensing node. It stays idle, issuing no memory or bus traffic, until a peripheral pulses one of its interrupt request lines. It then looks up the handler start address for that request in a vector table held in shared program memory. It runs the handler, which is a short program of 16-bit instructions, and returns to idle when the handler executes its terminate instruction.

A handler has no arithmetic. It can power slave devices up or down through a bank of power-enable lines, jump within the program, and move data between devices over a simple synchronous system bus. Moving data can mean a single read into an internal holding register, a write of that register, a write of an immediate constant, or a block copy from one device to another. A typical periodic handler powers a sensor, copies its samples into a message unit, powers the sensor down again, writes a start command to the message unit and terminates.

The program memory and the bus slaves both answer a read in the cycle after the request. Requests that arrive while a handler runs are remembered and served once it has terminated.

Top module: `event_sequencer`

## Requirements
- R1: Out of reset all power enables are off, and while no handler runs and no request is pending, `memRd`, `busRd` and `busWr` stay low.
- R2: A one-cycle pulse on `irqIn[i]` makes the block read program memory address i. The low 9 bits of the returned word are the address of the handler's first instruction.
- R3: When several requests are pending at dispatch time, the lowest-numbered one is served first.
- R4: A request raised while a handler runs is held and served after that handler terminates, even if it outranks the running one. Each pulse starts its handler exactly once.
- R5: Instruction layout: bits [15:13] opcode, [12:9] device index, [8:0] operand. Opcode values are 0 terminate, 1 power-on, 2 power-off, 3 jump, 4 read, 5 write, 6 write-immediate, 7 block copy. Instructions run in address order unless a jump intervenes.
- R6: Power-on sets and power-off clears only `pwrEn[device]`. The enables keep their value across handlers.
- R7: Block copy takes its source device from the device field, its destination device from operand [8:5] and its word count L from operand [4:0]. Word k (k = 0..L-1) is read from bus address {source, k} and written to {destination, k}, in ascending k. The next instruction runs only after the last word is written. L = 0 moves nothing.
- R8: Write-immediate writes the operand, zero-extended to 16 bits, to bus address {device, 0}.
- R9: Read loads the word at bus address {device, operand} into the holding register. Write stores the holding register to bus address {device, operand}.
- R10: Jump continues execution at the operand address. The instructions it skips have no effect.
- R11: Terminate ends the handler. The block then serves the next pending request or goes idle.
- R12: Bus read data is taken in the cycle after `busRd`. `busRd` and `busWr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Interrupt request pulses, one per source |
| memRd | output | 1 | Program memory read strobe |
| memAddr | output | 9 | Program memory address |
| memData | input | 16 | Program memory data, valid the cycle after `memRd` |
| busRd | output | 1 | System bus read strobe |
| busWr | output | 1 | System bus write strobe |
| busAddr | output | 13 | Bus address: device index in [12:9], offset in [8:0] |
| busWdata | output | 16 | Bus write data |
| busRdata | input | 16 | Bus read data, valid the cycle after `busRd` |
| pwrEn | output | 16 | Power enable, one per slave device |

## Verification
A corrupted program counter or a wrong instruction latch shows at the ports on the next fetch. It appears as a wrong `memAddr`, or as a wrong bus address or data within two cycles. A wrong transfer counter gives misplaced or missing writes during the copy itself. A pending-request register that loses or duplicates a bit shows only after the current handler terminates, as a missing, extra or reordered write burst. Power-enable faults stay visible on `pwrEn` indefinitely, because nothing but an instruction changes them.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
  parameter int DATA_W = 16;
  parameter int OPC_W  = 3;
  parameter int DEV_W  = 4;
  parameter int OPND_W = 9;
  parameter int LEN_W  = 5;
  parameter int IRQ_N  = 8;

  localparam int NUM_DEV = 1 << DEV_W;
  localparam int BUS_AW  = DEV_W + OPND_W;
  localparam int PC_W    = OPND_W;
  localparam int IRQ_W   = $clog2(IRQ_N);

  typedef enum logic [OPC_W-1:0] {
    OP_END   = 3'd0,
    OP_PWRON = 3'd1,
    OP_PWROF = 3'd2,
    OP_JMP   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5,
    OP_IMM   = 3'd6,
    OP_COPY  = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_DEVRD, BUS_REGWR, BUS_IMMWR, BUS_CPYRD, BUS_CPYWR
  } busop_e;

  typedef enum logic [1:0] {
    MEM_IDLE, MEM_VECTOR, MEM_PROG
  } memop_e;

  typedef struct packed {
    logic             liveInstr;
    logic             irLoad;
    logic             pcVector;
    logic             pcInc;
    logic             pcJump;
    logic             regLoad;
    logic             pwrSet;
    logic             pwrClr;
    logic             cntClr;
    logic             cntInc;
    busop_e           busOp;
    memop_e           memOp;
    logic [IRQ_W-1:0] vecIdx;
  } strobe_t;
endpackage

// File: rtl/evseq_irq.sv
module evseq_irq
  import evseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IRQ_N-1:0] irqIn,
  input  logic             take,
  output logic             pendAny,
  output logic [IRQ_W-1:0] grantIdx
);
  logic [IRQ_N-1:0] pending;
  logic [IRQ_N-1:0] clrMask;

  // lowest index wins: the descending loop leaves the smallest set index
  always_comb begin
    grantIdx = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (pending[i]) grantIdx = IRQ_W'(i);
    end
  end

  assign pendAny = |pending;
  assign clrMask = take ? (IRQ_N'(1) << grantIdx) : '0;

  // a new pulse on the granted line in the take cycle is kept (set over clear)
  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= (pending & ~clrMask) | irqIn;
  end

  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    take |-> pendAny); // R2

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    pendAny |-> (pending[grantIdx] &&
      ((pending & ((IRQ_N'(1) << grantIdx) - IRQ_N'(1))) == '0))); // R3

  AST_PEND_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (pending[$past(grantIdx)] == $past(irqIn[grantIdx]))); // R4
endmodule

// File: rtl/evseq_ctrl.sv
module evseq_ctrl
  import evseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pendAny,
  input  logic [IRQ_W-1:0] grantIdx,
  input  logic [OPC_W-1:0] liveOp,
  input  logic [LEN_W-1:0] liveLen,
  input  logic             xferLast,
  output logic             take,
  output strobe_t          st
);
  typedef enum logic [2:0] {
    S_IDLE, S_VEC, S_FETCH, S_EXEC, S_RDWAIT, S_XRD, S_XWR
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    st   = '0;
    take = 1'b0;
    nxt  = state;
    case (state)
      S_IDLE: begin
        if (pendAny) begin
          st.memOp  = MEM_VECTOR;
          st.vecIdx = grantIdx;
          take      = 1'b1;
          nxt       = S_VEC;
        end
      end
      S_VEC: begin
        st.pcVector = 1'b1;
        nxt         = S_FETCH;
      end
      S_FETCH: begin
        st.memOp = MEM_PROG;
        nxt      = S_EXEC;
      end
      S_EXEC: begin
        st.liveInstr = 1'b1;
        st.irLoad    = 1'b1;
        nxt          = S_FETCH;
        case (opcode_e'(liveOp))
          OP_END:   nxt = S_IDLE;
          OP_PWRON: begin st.pwrSet = 1'b1; st.pcInc = 1'b1; end
          OP_PWROF: begin st.pwrClr = 1'b1; st.pcInc = 1'b1; end
          OP_JMP:   st.pcJump = 1'b1;
          OP_LOAD:  begin st.busOp = BUS_DEVRD; nxt = S_RDWAIT; end
          OP_STORE: begin st.busOp = BUS_REGWR; st.pcInc = 1'b1; end
          OP_IMM:   begin st.busOp = BUS_IMMWR; st.pcInc = 1'b1; end
          OP_COPY: begin
            if (liveLen == '0) st.pcInc = 1'b1;
            else begin
              st.cntClr = 1'b1;
              nxt       = S_XRD;
            end
          end
          default: nxt = S_IDLE;
        endcase
      end
      S_RDWAIT: begin
        st.regLoad = 1'b1;
        st.pcInc   = 1'b1;
        nxt        = S_FETCH;
      end
      S_XRD: begin
        st.busOp = BUS_CPYRD;
        nxt      = S_XWR;
      end
      S_XWR: begin
        st.busOp  = BUS_CPYWR;
        st.cntInc = 1'b1;
        if (xferLast) begin
          st.pcInc = 1'b1;
          nxt      = S_FETCH;
        end else begin
          nxt = S_XRD;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  AST_XFER_HOLD_PC: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_XWR && !xferLast) |=> (state == S_XRD)); // R7
endmodule

// File: rtl/evseq_dpath.sv
module evseq_dpath
  import evseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [DATA_W-1:0]  memData,
  input  logic [DATA_W-1:0]  busRdata,
  output logic               memRd,
  output logic [PC_W-1:0]    memAddr,
  output logic               busRd,
  output logic               busWr,
  output logic [BUS_AW-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWdata,
  output logic [NUM_DEV-1:0] pwrEn,
  output logic               xferLast
);
  logic [PC_W-1:0]   pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] holdReg;
  logic [LEN_W-1:0]  cnt;

  logic [DATA_W-1:0] cur;
  logic [DEV_W-1:0]  curDev;
  logic [OPND_W-1:0] curOpnd;
  logic [DEV_W-1:0]  irDev;
  logic [DEV_W-1:0]  irDst;
  logic [LEN_W-1:0]  irLen;

  assign cur     = st.liveInstr ? memData : ir;
  assign curDev  = cur[OPND_W +: DEV_W];
  assign curOpnd = cur[0 +: OPND_W];
  assign irDev   = ir[OPND_W +: DEV_W];
  assign irDst   = ir[LEN_W +: DEV_W];
  assign irLen   = ir[0 +: LEN_W];
  assign xferLast = (cnt == (irLen - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      ir      <= '0;
      holdReg <= '0;
      cnt     <= '0;
      pwrEn   <= '0;
    end else begin
      if (st.pcVector)    pc <= memData[PC_W-1:0];
      else if (st.pcJump) pc <= curOpnd;
      else if (st.pcInc)  pc <= pc + PC_W'(1);
      if (st.irLoad)  ir <= memData;
      if (st.regLoad) holdReg <= busRdata;
      if (st.cntClr)      cnt <= '0;
      else if (st.cntInc) cnt <= cnt + LEN_W'(1);
      if (st.pwrSet)      pwrEn[curDev] <= 1'b1;
      else if (st.pwrClr) pwrEn[curDev] <= 1'b0;
    end
  end

  always_comb begin
    memRd   = 1'b0;
    memAddr = pc;
    case (st.memOp)
      MEM_VECTOR: begin memRd = 1'b1; memAddr = PC_W'(st.vecIdx); end
      MEM_PROG:   begin memRd = 1'b1; memAddr = pc; end
      default:    memRd = 1'b0;
    endcase
  end

  always_comb begin
    busRd    = 1'b0;
    busWr    = 1'b0;
    busAddr  = '0;
    busWdata = '0;
    case (st.busOp)
      BUS_DEVRD: begin
        busRd   = 1'b1;
        busAddr = {curDev, curOpnd};
      end
      BUS_REGWR: begin
        busWr    = 1'b1;
        busAddr  = {curDev, curOpnd};
        busWdata = holdReg;
      end
      BUS_IMMWR: begin
        busWr    = 1'b1;
        busAddr  = {curDev, OPND_W'(0)};
        busWdata = DATA_W'(curOpnd);
      end
      BUS_CPYRD: begin
        busRd   = 1'b1;
        busAddr = {irDev, OPND_W'(cnt)};
      end
      BUS_CPYWR: begin
        busWr    = 1'b1;
        busAddr  = {irDst, OPND_W'(cnt)};
        busWdata = busRdata;
      end
      default: busRd = 1'b0;
    endcase
  end

  AST_PWR_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(st.pwrSet || st.pwrClr) |=> $stable(pwrEn)); // R6

  AST_PWR_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pwrEn ^ $past(pwrEn)) <= 1); // R6

  AST_XFER_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (st.busOp == BUS_CPYWR) |-> (cnt < irLen)); // R7
endmodule

// File: rtl/event_sequencer.sv
module event_sequencer
  import evseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [IRQ_N-1:0]   irqIn,
  output logic               memRd,
  output logic [PC_W-1:0]    memAddr,
  input  logic [DATA_W-1:0]  memData,
  output logic               busRd,
  output logic               busWr,
  output logic [BUS_AW-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWdata,
  input  logic [DATA_W-1:0]  busRdata,
  output logic [NUM_DEV-1:0] pwrEn
);
  logic             pendAny;
  logic [IRQ_W-1:0] grantIdx;
  logic             take;
  logic             xferLast;
  strobe_t          st;

  evseq_irq u_irq (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .take     (take),
    .pendAny  (pendAny),
    .grantIdx (grantIdx)
  );

  evseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pendAny  (pendAny),
    .grantIdx (grantIdx),
    .liveOp   (memData[DATA_W-1 -: OPC_W]),
    .liveLen  (memData[LEN_W-1:0]),
    .xferLast (xferLast),
    .take     (take),
    .st       (st)
  );

  evseq_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .memData  (memData),
    .busRdata (busRdata),
    .memRd    (memRd),
    .memAddr  (memAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .pwrEn    (pwrEn),
    .xferLast (xferLast)
  );

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr)); // R12
endmodule

// File: tb/event_sequencer_bench.sv
`timescale 1ns/1ps
module event_sequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  irqIn = '0;
  logic        memRd;
  logic [8:0]  memAddr;
  logic [15:0] memData = '0;
  logic        busRd, busWr;
  logic [12:0] busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata = '0;
  logic [15:0] pwrEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] mem [0:511];
  logic [12:0] logAddr [0:1023];
  logic [15:0] logData [0:1023];
  logic [15:0] logPwr  [0:1023];
  int logCnt = 0;
  int accCnt = 0;

  always #2.5 clk = ~clk;

  event_sequencer u_event_sequencer (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwrEn(pwrEn)
  );

  // memory and slave models: registered read, one cycle latency
  always @(posedge clk) begin
    if (memRd) memData <= mem[memAddr];
    if (busRd) busRdata <= {3'b101, busAddr};
    if (rstN && (memRd || busRd || busWr)) accCnt <= accCnt + 1;
    if (rstN && busWr) begin
      logAddr[logCnt] <= busAddr;
      logData[logCnt] <= busWdata;
      logPwr[logCnt]  <= pwrEn;
      logCnt <= logCnt + 1;
    end
  end

  function automatic logic [15:0] ins(input int op, input int dev, input int opnd);
    return {op[2:0], dev[3:0], opnd[8:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) irqIn = m;
    @(negedge clk) irqIn = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "pwrEn after reset", pwrEn, 0);
    chk("R1", "memRd after reset", memRd, 0);
    chk("R1", "bus strobes after reset", {busRd, busWr}, 0);
  endtask

  task automatic t_quiet;
    int base = accCnt;
    idle(40);
    chk("R1", "accesses while idle", accCnt - base, 0);
  endtask

  task automatic t_sense;
    int base = logCnt;
    int acc;
    mem[2] = 16'h020;          // R2 vector
    mem[9'h20] = ins(1, 3, 0);                 // R5 power on sensor
    mem[9'h21] = ins(7, 3, {4'd5, 5'd4});       // copy 4 words dev3 -> dev5
    mem[9'h22] = ins(2, 3, 0);
    mem[9'h23] = ins(6, 5, 9'h01F);
    mem[9'h24] = ins(0, 0, 0);
    pulse(8'h04);
    idle(60);
    chk("R7", "sense write count", logCnt - base, 5);
    for (int k = 0; k < 4; k++) begin
      chk("R7", "copy dest addr", logAddr[base+k], {4'd5, 9'(k)});
      chk("R7", "copy data", logData[base+k], {3'b101, 4'd3, 9'(k)});
      chk("R6", "sensor powered during copy", logPwr[base+k][3], 1);
    end
    chk("R8", "immediate addr", logAddr[base+4], {4'd5, 9'd0});
    chk("R8", "immediate data", logData[base+4], 16'h001F);
    chk("R6", "sensor off before command", logPwr[base+4][3], 0);
    chk("R6", "pwrEn after sense", pwrEn, 0);
    acc = accCnt;
    idle(20);
    chk("R11", "quiet after terminate", accCnt - acc, 0);
  endtask

  task automatic t_priority;
    int base = logCnt;
    mem[1] = 16'h040;
    mem[9'h40] = ins(6, 1, 9'h011);
    mem[9'h41] = ins(0, 0, 0);
    mem[6] = 16'h048;
    mem[9'h48] = ins(6, 6, 9'h066);
    mem[9'h49] = ins(0, 0, 0);
    pulse(8'h42);
    idle(40);
    chk("R3", "priority count", logCnt - base, 2);
    chk("R3", "first served addr", logAddr[base], {4'd1, 9'd0});
    chk("R3", "first served data", logData[base], 16'h0011);
    chk("R3", "second served data", logData[base+1], 16'h0066);
  endtask

  task automatic t_latch;
    int base = logCnt;
    mem[5] = 16'h050;
    mem[9'h50] = ins(6, 2, 9'h00A);
    mem[9'h51] = ins(6, 2, 9'h00B);
    mem[9'h52] = ins(6, 2, 9'h00C);
    mem[9'h53] = ins(0, 0, 0);
    mem[0] = 16'h058;
    mem[9'h58] = ins(6, 0, 9'h044);
    mem[9'h59] = ins(0, 0, 0);
    pulse(8'h20);
    idle(3);
    pulse(8'h01);
    idle(50);
    chk("R4", "latched count", logCnt - base, 4);
    chk("R4", "running handler finishes", logData[base+2], 16'h000C);
    chk("R4", "latched served after", logAddr[base+3], {4'd0, 9'd0});
    chk("R4", "latched data", logData[base+3], 16'h0044);
  endtask

  task automatic t_readwrite;
    int base = logCnt;
    mem[3] = 16'h060;
    mem[9'h60] = ins(4, 7, 9'h033);
    mem[9'h61] = ins(5, 9, 9'h044);
    mem[9'h62] = ins(0, 0, 0);
    pulse(8'h08);
    idle(40);
    chk("R9", "read/write count", logCnt - base, 1);
    chk("R9", "write addr", logAddr[base], {4'd9, 9'h044});
    chk("R12", "read data captured", logData[base], {3'b101, 4'd7, 9'h033});
  endtask

  task automatic t_jump;
    int base = logCnt;
    mem[7] = 16'h070;
    mem[9'h70] = ins(3, 0, 9'h074);
    mem[9'h71] = ins(6, 8, 9'h099);
    mem[9'h72] = ins(0, 0, 0);
    mem[9'h74] = ins(6, 8, 9'h055);
    mem[9'h75] = ins(0, 0, 0);
    pulse(8'h80);
    idle(40);
    chk("R10", "jump write count", logCnt - base, 1);
    chk("R10", "jump target data", logData[base], 16'h0055);
  endtask

  task automatic t_copy_edges;
    int base = logCnt;
    int bad = 0;
    mem[3] = 16'h080;
    mem[9'h80] = ins(7, 2, {4'd6, 5'd0});
    mem[9'h81] = ins(6, 6, 9'h077);
    mem[9'h82] = ins(7, 2, {4'd6, 5'd31});
    mem[9'h83] = ins(0, 0, 0);
    pulse(8'h08);
    idle(130);
    chk("R7", "edge copy count", logCnt - base, 32);
    chk("R7", "zero length moves nothing", logData[base], 16'h0077);
    for (int k = 0; k < 31; k++) begin
      if (logAddr[base+1+k] !== {4'd6, 9'(k)} ||
          logData[base+1+k] !== {3'b101, 4'd2, 9'(k)}) bad++;
    end
    chk("R7", "max length words in order", bad, 0);
  endtask

  task automatic t_power;
    mem[4] = 16'h090;
    mem[9'h90] = ins(1, 10, 0);
    mem[9'h91] = ins(1, 12, 0);
    mem[9'h92] = ins(2, 12, 0);
    mem[9'h93] = ins(0, 0, 0);
    pulse(8'h10);
    idle(30);
    chk("R6", "enable persists after handler", pwrEn, 16'h0400);
    mem[6] = 16'h098;
    mem[9'h98] = ins(1, 1, 0);
    mem[9'h99] = ins(0, 0, 0);
    pulse(8'h40);
    idle(30);
    chk("R6", "second handler adds bit", pwrEn, 16'h0402);
    mem[4] = 16'h0A0;
    mem[9'hA0] = ins(2, 10, 0);
    mem[9'hA1] = ins(0, 0, 0);
    pulse(8'h10);
    idle(30);
    chk("R6", "clear only named bit", pwrEn, 16'h0002);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_quiet();
    t_sense();
    t_priority();
    t_latch();
    t_readwrite();
    t_jump();
    t_copy_edges();
    t_power();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule